// File: doc/BRIEF.md
# Filtered Performance Event Counter Bank

This block holds a parameterised number of identical 48-bit event counters. Each counter has a filter in front of it. Every clock, the filter takes two per-cycle occurrence counts, one from the local hardware thread and one from the sibling thread, along with the current 2-bit privilege level. It then decides how much the counter advances in that cycle.

Each counter has its own configuration inputs:

- user-level and kernel-level privilege qualification;
- a mode that adds the sibling's occurrences to the local ones;
- an 8-bit threshold;
- inversion of the qualified condition;
- edge detection, so that a run of qualifying cycles is counted once.

Software-side logic outside this block can load each counter and clear its sticky overflow flag. It can also stop counting through a per-counter enable or a global enable.

All outputs are registered. An increment caused by the inputs in one cycle shows in the count after the next rising clock edge.

Top module: `pmc_bank`

## Requirements
- R1: Privilege qualification. With the user enable set, cycles at privilege level 1, 2 or 3 may count. With the kernel enable set, cycles at level 0 may count. With both set, every level counts. With neither set, nothing counts. This gating applies after inversion.
- R2: With a nonzero threshold, a qualifying cycle is one whose occurrence count is greater than or equal to the threshold. Each such cycle adds exactly 1.
- R3: With a threshold of 0 and no inversion, each qualifying cycle adds the raw occurrence count of that cycle.
- R4: Inversion makes the counter add 1 on the cycles where the condition is not met. With a nonzero threshold, that is a count below the threshold. With a threshold of 0, that is a count of zero.
- R5: With edge detection on, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous counting cycle. The history is forced to false while the per-counter enable is low. While only the global enable is low, the history is held.
- R6: With the any-thread mode on, local and sibling occurrences are summed before any comparison. With it off, the sibling input has no effect on the count.
- R7: A load strobe writes the load value into the counter on the next edge. The load overrides any increment in that cycle.
- R8: When an increment carries the counter past all ones, the counter keeps the low 48 bits and a sticky overflow flag is set. The flag stays set until its clear strobe is given. A wrap in the same cycle as a clear leaves the flag set.
- R9: While the global enable is low, no counter changes except through a load.
- R10: After reset, every counter and every overflow flag is zero. Each counter responds only to its own enable, configuration, occurrence inputs and strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| global_en | input | 1 | Global count enable |
| priv_lvl | input | 2 | Current privilege level (0 = kernel) |
| local_occ | input | NUM_CNT*OCC_W | Per-counter local-thread occurrence count |
| sibling_occ | input | NUM_CNT*OCC_W | Per-counter sibling-thread occurrence count |
| cnt_en | input | NUM_CNT | Per-counter enable |
| cfg_user | input | NUM_CNT | Count at privilege levels 1 to 3 |
| cfg_kernel | input | NUM_CNT | Count at privilege level 0 |
| cfg_invert | input | NUM_CNT | Invert the qualified condition |
| cfg_edge | input | NUM_CNT | Count rising edges of the condition only |
| cfg_anythread | input | NUM_CNT | Sum both threads' occurrences |
| cfg_thresh | input | NUM_CNT*8 | Per-counter threshold |
| load_en | input | NUM_CNT | Per-counter load strobe |
| load_val | input | CNT_W | Value written by a load |
| ovf_clr | input | NUM_CNT | Per-counter overflow clear strobe |
| cnt_value | output | NUM_CNT*CNT_W | Counter values |
| ovf_flag | output | NUM_CNT | Sticky overflow flags |

## Verification
The hardest state to reach from the ports is a counter wrap. Counting up from zero would take 2^48 increments, so the stimulus loads a value a few counts below all ones and then drives large raw occurrence counts with the threshold at 0. Clear strobes are mixed in to hit the case where a wrap and a clear fall in the same cycle. Edge-detect history is also hard to observe, because it only shows through the count. The stimulus therefore toggles the per-counter and global enables at random during edge-detect runs. The bench's model then predicts where a rising edge is counted again.

// File: rtl/pmc_pkg.sv
// Package: shared configuration type for the filtered event counter bank.
// Assumes: threshold is always 8 bits; other widths come from module parameters.
package pmc_pkg;

    localparam int THRESH_W = 8;

    typedef struct packed {
        logic                user;
        logic                kernel;
        logic                invert;
        logic                edge_det;
        logic                any_thread;
        logic [THRESH_W-1:0] thresh;
    } pmc_cfg_t;

endpackage

// File: rtl/pmc_qualifier.sv
// Module: pmc_qualifier
// Turns per-cycle occurrence counts into an increment amount. The chain is:
// thread sum, then threshold compare, then inversion, then privilege gate, then edge detect.
// Assumes: cnt_en low clears the edge history; a low global enable (active low
// while cnt_en high) holds it.
module pmc_qualifier
    import pmc_pkg::*;
#(
    parameter int OCC_W = 4,
    localparam int SUM_W = OCC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmc_cfg_t         cfg,
    input  logic [1:0]       priv_lvl,
    input  logic [OCC_W-1:0] local_occ,
    input  logic [OCC_W-1:0] sibling_occ,
    input  logic             cnt_en,
    input  logic             active,
    output logic [SUM_W-1:0] inc_amt
);

    logic [SUM_W-1:0] occ_sum;
    logic             raw_cond;
    logic             inv_cond;
    logic             priv_ok;
    logic             qualified;
    logic             prev_q;

    // Combine thread occurrences according to the any-thread mode.
    always_comb begin
        occ_sum = SUM_W'(local_occ);
        if (cfg.any_thread) begin
            occ_sum = SUM_W'(local_occ) + SUM_W'(sibling_occ);
        end
    end

    // Threshold compare, inversion and privilege gating.
    always_comb begin
        if (cfg.thresh != '0) begin
            raw_cond = (SUM_W + THRESH_W)'(occ_sum) >= (SUM_W + THRESH_W)'(cfg.thresh);
        end else begin
            raw_cond = (occ_sum != '0);
        end
        inv_cond  = raw_cond ^ cfg.invert;
        priv_ok   = (cfg.kernel && (priv_lvl == 2'd0)) ||
                    (cfg.user   && (priv_lvl != 2'd0));
        qualified = inv_cond && priv_ok;
    end

    // Increment amount: raw sum, a unit step, or a unit step on a rising edge.
    always_comb begin
        inc_amt = '0;
        if (cfg.edge_det) begin
            if (qualified && !prev_q) begin
                inc_amt = SUM_W'(1);
            end
        end else if (qualified) begin
            if ((cfg.thresh == '0) && !cfg.invert) begin
                inc_amt = occ_sum;
            end else begin
                inc_amt = SUM_W'(1);
            end
        end
    end

    // Edge history: cleared while disabled, updated on counting cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (!cnt_en) begin
            prev_q <= 1'b0;
        end else if (active) begin
            prev_q <= qualified;
        end
    end

    // R1: with no privilege enable for the current level, nothing is added.
    p_priv_gate_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_lvl == 2'd0 && !cfg.kernel) || (priv_lvl != 2'd0 && !cfg.user))
        |-> inc_amt == '0);

    // R2: a nonzero threshold yields at most a unit step.
    p_thresh_unit_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.thresh != '0) |-> inc_amt <= SUM_W'(1));

    // R5: edge mode never adds twice in a row while counting continues.
    p_edge_once_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.edge_det && active && inc_amt != '0) |=>
        (!(cfg.edge_det && $stable(cfg) && active) || inc_amt == '0));

endmodule

// File: rtl/pmc_counter.sv
// Module: pmc_counter
// A 48-bit (parameterised) accumulating counter with a load port and a sticky overflow flag.
// Assumes: a load overrides an increment; a wrap in the same cycle as a clear leaves the flag set.
module pmc_counter #(
    parameter int CNT_W = 48,
    parameter int AMT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [AMT_W-1:0] inc_amt,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W:0] next_sum;
    logic           carry;

    // Adder with carry out.
    always_comb begin
        next_sum = {1'b0, cnt} + (CNT_W + 1)'(inc_amt);
        carry    = next_sum[CNT_W];
    end

    // Counter register: load has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (active) begin
            cnt <= next_sum[CNT_W-1:0];
        end
    end

    // Sticky overflow: a wrap sets it, a clear strobe resets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (!load_en && active && carry) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    // R7: a load shows its value on the next edge.
    p_load_wins_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cnt == $past(load_val));

    // R9: without activity or load the counter holds.
    p_hold_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load_en) |=> $stable(cnt));

    // R8: the flag stays set unless cleared.
    p_ovf_sticky_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R8: the flag rises only on a wrap of an incrementing counter.
    p_ovf_rise_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(active) && !$past(load_en) && cnt < $past(cnt)));

endmodule

// File: rtl/pmc_bank.sv
// Module: pmc_bank (top)
// NUM_CNT identical filtered counters. Privilege level, global enable and load value are shared.
// Assumes: per-counter buses are packed with counter 0 in the low slice.
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int OCC_W   = 4,
    parameter int CNT_W   = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        global_en,
    input  logic [1:0]                  priv_lvl,
    input  logic [NUM_CNT*OCC_W-1:0]    local_occ,
    input  logic [NUM_CNT*OCC_W-1:0]    sibling_occ,
    input  logic [NUM_CNT-1:0]          cnt_en,
    input  logic [NUM_CNT-1:0]          cfg_user,
    input  logic [NUM_CNT-1:0]          cfg_kernel,
    input  logic [NUM_CNT-1:0]          cfg_invert,
    input  logic [NUM_CNT-1:0]          cfg_edge,
    input  logic [NUM_CNT-1:0]          cfg_anythread,
    input  logic [NUM_CNT*8-1:0]        cfg_thresh,
    input  logic [NUM_CNT-1:0]          load_en,
    input  logic [CNT_W-1:0]            load_val,
    input  logic [NUM_CNT-1:0]          ovf_clr,
    output logic [NUM_CNT*CNT_W-1:0]    cnt_value,
    output logic [NUM_CNT-1:0]          ovf_flag
);

    localparam int AMT_W = OCC_W + 1;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pmc_cfg_t         cfg;
        logic             active;
        logic [AMT_W-1:0] amt;

        // Gather this counter's configuration and activity.
        always_comb begin
            cfg.user       = cfg_user[g];
            cfg.kernel     = cfg_kernel[g];
            cfg.invert     = cfg_invert[g];
            cfg.edge_det   = cfg_edge[g];
            cfg.any_thread = cfg_anythread[g];
            cfg.thresh     = cfg_thresh[g*8 +: 8];
            active         = global_en && cnt_en[g];
        end

        pmc_qualifier #(.OCC_W(OCC_W)) u_qual (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg         (cfg),
            .priv_lvl    (priv_lvl),
            .local_occ   (local_occ[g*OCC_W +: OCC_W]),
            .sibling_occ (sibling_occ[g*OCC_W +: OCC_W]),
            .cnt_en      (cnt_en[g]),
            .active      (active),
            .inc_amt     (amt)
        );

        pmc_counter #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active),
            .inc_amt  (amt),
            .load_en  (load_en[g]),
            .load_val (load_val),
            .ovf_clr  (ovf_clr[g]),
            .cnt      (cnt_value[g*CNT_W +: CNT_W]),
            .ovf      (ovf_flag[g])
        );
    end

endmodule

// File: tb/pmc_bank_test.sv
`timescale 1ns/1ps
// Bench: a behavioural per-counter model, compared against every counter on every clock.
module pmc_bank_test;

    localparam int N   = 4;
    localparam int OW  = 4;
    localparam int CW  = 48;
    localparam int OMAX = (1 << OW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            global_en = 1'b0;
    logic [1:0]      priv_lvl = '0;
    logic [N*OW-1:0] local_occ = '0;
    logic [N*OW-1:0] sibling_occ = '0;
    logic [N-1:0]    cnt_en = '0;
    logic [N-1:0]    cfg_user = '0, cfg_kernel = '0, cfg_invert = '0;
    logic [N-1:0]    cfg_edge = '0, cfg_anythread = '0;
    logic [N*8-1:0]  cfg_thresh = '0;
    logic [N-1:0]    load_en = '0;
    logic [CW-1:0]   load_val = '0;
    logic [N-1:0]    ovf_clr = '0;
    logic [N*CW-1:0] cnt_value;
    logic [N-1:0]    ovf_flag;

    pmc_bank #(.NUM_CNT(N), .OCC_W(OW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .global_en(global_en), .priv_lvl(priv_lvl),
        .local_occ(local_occ), .sibling_occ(sibling_occ), .cnt_en(cnt_en),
        .cfg_user(cfg_user), .cfg_kernel(cfg_kernel), .cfg_invert(cfg_invert),
        .cfg_edge(cfg_edge), .cfg_anythread(cfg_anythread), .cfg_thresh(cfg_thresh),
        .load_en(load_en), .load_val(load_val), .ovf_clr(ovf_clr),
        .cnt_value(cnt_value), .ovf_flag(ovf_flag)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;

    logic [CW-1:0] m_cnt  [N];
    logic          m_ovf  [N];
    logic          m_prev [N];

    // Random knobs used by run().
    bit k_priv = 0, k_en = 0, k_gen = 0, k_load = 0, k_clr = 0, k_high = 0;

    task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model: advance every counter by one clock from the current inputs.
    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            int s, th, amt;
            bit cond, q, pok, act;
            logic [CW:0] nx;
            s   = int'(local_occ[i*OW +: OW]);
            if (cfg_anythread[i]) s += int'(sibling_occ[i*OW +: OW]);
            th  = int'(cfg_thresh[i*8 +: 8]);
            cond = (th != 0) ? (s >= th) : (s != 0);
            pok = (priv_lvl == 0) ? cfg_kernel[i] : cfg_user[i];
            q   = (cond ^ cfg_invert[i]) && pok;
            act = global_en && cnt_en[i];
            if (cfg_edge[i])                     amt = (q && !m_prev[i]) ? 1 : 0;
            else if (!q)                         amt = 0;
            else if (th == 0 && !cfg_invert[i])  amt = s;
            else                                 amt = 1;
            nx = {1'b0, m_cnt[i]} + (CW + 1)'(amt);
            if (load_en[i])   m_cnt[i] = load_val;
            else if (act)     m_cnt[i] = nx[CW-1:0];
            if (!load_en[i] && act && nx[CW]) m_ovf[i] = 1'b1;
            else if (ovf_clr[i])              m_ovf[i] = 1'b0;
            if (!cnt_en[i])  m_prev[i] = 1'b0;
            else if (act)    m_prev[i] = q;
        end
    endtask

    task automatic clock_and_check(input string tag);
        model_step();
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            chk(cnt_value[i*CW +: CW] === m_cnt[i], tag, cnt_value[i*CW +: CW], m_cnt[i]);
            chk(ovf_flag[i] === m_ovf[i], {tag, " ovf"}, CW'(ovf_flag[i]), CW'(m_ovf[i]));
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < N; i++) begin
                local_occ[i*OW +: OW]   = k_high ? OW'($urandom_range(OMAX - 3, OMAX))
                                                 : OW'($urandom_range(0, OMAX));
                sibling_occ[i*OW +: OW] = OW'($urandom_range(0, OMAX));
                if (k_en) cnt_en[i] = ($urandom_range(0, 3) != 0);
            end
            if (k_priv) priv_lvl = 2'($urandom_range(0, 3));
            if (k_gen)  global_en = ($urandom_range(0, 3) != 0);
            load_en  = k_load ? N'($urandom) & N'($urandom) : '0;
            load_val = {16'($urandom), 32'($urandom)};
            ovf_clr  = k_clr ? N'($urandom) : '0;
            clock_and_check(tag);
        end
        load_en = '0;
        ovf_clr = '0;
    endtask

    task automatic knobs_off();
        k_priv = 0; k_en = 0; k_gen = 0; k_load = 0; k_clr = 0; k_high = 0;
        global_en = 1; cnt_en = '1;
        cfg_user = '1; cfg_kernel = '1; cfg_invert = '0; cfg_edge = '0;
        cfg_anythread = '0; cfg_thresh = '0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = '0; m_ovf[i] = 0; m_prev[i] = 0;
        end
        // Hold reset with counting configured, to show reset wins.
        knobs_off();
        local_occ = '1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state.
        for (int i = 0; i < N; i++) begin
            chk(cnt_value[i*CW +: CW] === '0, "R10 reset count", cnt_value[i*CW +: CW], '0);
            chk(ovf_flag[i] === 1'b0, "R10 reset ovf", CW'(ovf_flag[i]), '0);
        end

        // R3: raw accumulation with threshold 0.
        knobs_off();
        run(40, "R3 raw sum");

        // R1: privilege combinations differ per counter.
        knobs_off(); k_priv = 1;
        cfg_user = 4'b0101; cfg_kernel = 4'b0011;
        run(80, "R1 privilege");

        // R2: thresholds 1, 5, 9, 15.
        knobs_off(); k_priv = 1;
        cfg_thresh = {8'd15, 8'd9, 8'd5, 8'd1};
        run(80, "R2 threshold");

        // R4: inversion with and without a threshold.
        knobs_off();
        cfg_invert = '1;
        cfg_thresh = {8'd0, 8'd12, 8'd0, 8'd6};
        run(80, "R4 invert");

        // R6: any-thread on counters 0 and 2; threshold beyond one thread on counter 2.
        knobs_off();
        cfg_anythread = 4'b0101;
        cfg_thresh = {8'd0, 8'd20, 8'd0, 8'd0};
        run(80, "R6 any thread");

        // R5: edge detection with enables toggling.
        knobs_off(); k_en = 1; k_gen = 1; k_priv = 1;
        cfg_edge = '1;
        cfg_thresh = {8'd3, 8'd8, 8'd0, 8'd10};
        cfg_invert = 4'b0100;
        run(200, "R5 edge detect");

        // R7: loads mixed with increments.
        knobs_off(); k_load = 1;
        run(60, "R7 load priority");

        // R9: global enable low, with a few loads.
        knobs_off(); global_en = 0; k_load = 1;
        run(40, "R9 global hold");

        // R8: preload near all ones, then wrap with large counts; clear at random.
        for (int rep = 0; rep < 6; rep++) begin
            knobs_off();
            load_en = '1;
            load_val = {CW{1'b1}} - CW'($urandom_range(0, 40));
            clock_and_check("R8 preload");
            k_high = 1; k_clr = (rep >= 2);
            run(12, "R8 wrap and clear");
        end
        knobs_off(); ovf_clr = '1;
        clock_and_check("R8 clear");

        // R10: fully random mix, counters independent.
        knobs_off(); k_priv = 1; k_en = 1; k_gen = 1; k_load = 1; k_clr = 1;
        for (int rep = 0; rep < 10; rep++) begin
            cfg_user = N'($urandom); cfg_kernel = N'($urandom);
            cfg_invert = N'($urandom); cfg_edge = N'($urandom);
            cfg_anythread = N'($urandom);
            for (int i = 0; i < N; i++)
                cfg_thresh[i*8 +: 8] = ($urandom_range(0, 2) == 0) ? 8'd0 : 8'($urandom_range(1, 31));
            run(50, "R10 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule